// File: doc/BRIEF.md
# Vectored interrupt priority controller

The controller gathers a bank of level-sensitive interrupt request lines and presents a single IRQ line to a processor. Sixteen vectored slots each pick one request line through a source select and carry their own handler address. Slot 0 has the highest priority and slot 15 the lowest. A request line that is enabled but claimed by no enabled slot belongs to one shared default level. That level ranks below every slot and is served through a separate default handler address.

Software talks to the block through a simple 32-bit register port with separate read and write strobes. A read of the active-vector register at offset 0x030 is the acknowledge. It returns the handler address of the winning request and marks that level as in service. A write to the same offset, with any data, is the end of service: it retires the most recent in-service level. An in-service stack of 17 bits, one per slot plus one for the default level, holds the nesting. Only a request strictly above the highest level in service can raise IRQ again.

The register port is a control interface, not a data stream. Every strobe is taken in the cycle it is presented, so the port has no valid/ready handshake and never applies back-pressure. Read data is registered and appears in the cycle after the read strobe.

Top module: `vic_ctrl`

## Requirements
- R1: After reset, irq_o is low, every configuration register reads 0, and the first read of offset 0x030 returns 0.
- R2: Slot n is active when its enable bit is set, its selected source line is high, and that source's bit in the source-enable mask (offset 0x010) is set. Among active levels, the lowest slot number wins, and an acknowledge read returns the handler address of that slot.
- R3: An enabled, high source line that no enabled slot selects raises the default level (level 16). This level is below all slots, and its acknowledge returns the default address held at offset 0x034. A line whose mask bit is clear has no effect.
- R4: An acknowledge read that finds a pending level sets that level's in-service bit. While that bit is set, requests at the same level and at lower levels do not raise irq_o.
- R5: irq_o is high exactly when some active level is numerically lower than the lowest-numbered in-service level (17 when none is in service). It follows request changes in the same cycle, with no register in the path.
- R6: A write to offset 0x030 clears the lowest-numbered set in-service bit, and the write data is ignored. The same write with no bit set changes nothing.
- R7: A read of offset 0x030 with nothing pending returns the default address and sets no in-service bit.
- R8: Read data is registered. It appears in the cycle after the read strobe, and it holds the value decided at the strobe cycle even if requests change afterwards.
- R9: Slot handler addresses live at 0x100 + 4n and slot controls at 0x200 + 4n. In a slot control word, bit 5 is the enable and bits 4:0 are the source select. All configuration registers read back what was last written.
- R10: A higher-priority request preempts a level already in service and nests on top of it. After the inner level's end-of-service write, the outer level's masking applies again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_src | input | 32 | Level-sensitive request lines |
| reg_addr | input | 10 | Byte offset of the register access |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
irq_o is due in the same cycle as the request or in-service change that drives it. The bench therefore drives inputs at the falling edge and compares irq_o with the reference model just before the next rising edge. Read data, and any in-service change caused by an acknowledge or end-of-service strobe, appear one rising edge after the strobe. The bench samples reg_rdata shortly after that edge and updates its model stack at the same edge, so the next cycle's irq_o comparison sees the new nesting state.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned ADDR_W   = 10;
  localparam int unsigned DATA_W   = 32;
  localparam logic [ADDR_W-1:0] OFF_SRC_EN = 10'h010;
  localparam logic [ADDR_W-1:0] OFF_ACTIVE = 10'h030;
  localparam logic [ADDR_W-1:0] OFF_DEFVEC = 10'h034;
  localparam logic [1:0] REGION_VEC = 2'b01;
  localparam logic [1:0] REGION_CTL = 2'b10;
endpackage

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 32,
  parameter int unsigned NUM_SLOT = 16,
  localparam int unsigned SRC_W   = $clog2(NUM_SRC),
  localparam int unsigned SLOT_W  = $clog2(NUM_SLOT)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [DATA_W-1:0]                 wdata,
  output logic [NUM_SLOT-1:0][DATA_W-1:0]   slot_addr,
  output logic [NUM_SLOT-1:0]               slot_en,
  output logic [NUM_SLOT-1:0][SRC_W-1:0]    slot_sel,
  output logic [NUM_SRC-1:0]                src_en,
  output logic [DATA_W-1:0]                 def_addr,
  output logic [DATA_W-1:0]                 cfg_rdata
);
  localparam int unsigned PAD_W = ADDR_W - 2 - SLOT_W - 2;

  logic              in_slot_area;
  logic              hit_vec;
  logic              hit_ctl;
  logic [SLOT_W-1:0] idx;

  assign idx          = addr[SLOT_W+1:2];
  assign in_slot_area = (addr[ADDR_W-3:SLOT_W+2] == PAD_W'(0)) && (addr[1:0] == 2'b00);
  assign hit_vec      = in_slot_area && (addr[ADDR_W-1:ADDR_W-2] == REGION_VEC);
  assign hit_ctl      = in_slot_area && (addr[ADDR_W-1:ADDR_W-2] == REGION_CTL);

  for (genvar g = 0; g < NUM_SLOT; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_addr[g] <= '0;
        slot_en[g]   <= 1'b0;
        slot_sel[g]  <= '0;
      end else if (wr_en) begin
        if (hit_vec && idx == SLOT_W'(g)) slot_addr[g] <= wdata;
        if (hit_ctl && idx == SLOT_W'(g)) begin
          slot_en[g]  <= wdata[SRC_W];
          slot_sel[g] <= wdata[SRC_W-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_en   <= '0;
      def_addr <= '0;
    end else if (wr_en) begin
      if (addr == OFF_SRC_EN) src_en   <= wdata[NUM_SRC-1:0];
      if (addr == OFF_DEFVEC) def_addr <= wdata;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (hit_vec) begin
      cfg_rdata = slot_addr[idx];
    end else if (hit_ctl) begin
      cfg_rdata = {{(DATA_W-SRC_W-1){1'b0}}, slot_en[idx], slot_sel[idx]};
    end else if (addr == OFF_SRC_EN) begin
      cfg_rdata = DATA_W'(src_en);
    end else if (addr == OFF_DEFVEC) begin
      cfg_rdata = def_addr;
    end
  end
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int unsigned NUM_SRC  = 32,
  parameter int unsigned NUM_SLOT = 16,
  localparam int unsigned SRC_W   = $clog2(NUM_SRC),
  localparam int unsigned NUM_LVL = NUM_SLOT + 1,
  localparam int unsigned LVL_W   = $clog2(NUM_LVL + 1)
) (
  input  logic [NUM_SRC-1:0]             irq_src,
  input  logic [NUM_SRC-1:0]             src_en,
  input  logic [NUM_SLOT-1:0]            slot_en,
  input  logic [NUM_SLOT-1:0][SRC_W-1:0] slot_sel,
  input  logic [LVL_W-1:0]               isr_top,
  output logic                           pend_valid,
  output logic [LVL_W-1:0]               pend_lvl
);
  logic [NUM_SRC-1:0] req;
  logic [NUM_SRC-1:0] claimed;
  logic [NUM_LVL-1:0] lvl_act;
  logic [LVL_W-1:0]   best;

  assign req = irq_src & src_en;

  always_comb begin
    claimed = '0;
    for (int s = 0; s < NUM_SLOT; s++) begin
      if (slot_en[s]) claimed[slot_sel[s]] = 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_SLOT; g++) begin : g_act
    assign lvl_act[g] = slot_en[g] & req[slot_sel[g]];
  end
  assign lvl_act[NUM_SLOT] = |(req & ~claimed);

  always_comb begin
    best = LVL_W'(NUM_LVL);
    for (int i = NUM_LVL - 1; i >= 0; i--) begin
      if (lvl_act[i]) best = LVL_W'(i);
    end
  end

  assign pend_lvl   = best;
  assign pend_valid = (best < isr_top);
endmodule

// File: rtl/vic_stack.sv
module vic_stack #(
  parameter int unsigned NUM_LVL = 17,
  localparam int unsigned LVL_W  = $clog2(NUM_LVL + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic [LVL_W-1:0]   push_lvl,
  input  logic               pop,
  output logic [NUM_LVL-1:0] isr,
  output logic [LVL_W-1:0]   top
);
  logic [NUM_LVL-1:0] isr_nxt;

  always_comb begin
    isr_nxt = isr;
    if (pop)  isr_nxt = isr & (isr - NUM_LVL'(1));
    if (push) isr_nxt = isr_nxt | (NUM_LVL'(1) << push_lvl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr <= '0;
    else        isr <= isr_nxt;
  end

  always_comb begin
    top = LVL_W'(NUM_LVL);
    for (int i = NUM_LVL - 1; i >= 0; i--) begin
      if (isr[i]) top = LVL_W'(i);
    end
  end
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 32,
  parameter int unsigned NUM_SLOT = 16,
  localparam int unsigned SRC_W   = $clog2(NUM_SRC),
  localparam int unsigned SLOT_W  = $clog2(NUM_SLOT),
  localparam int unsigned NUM_LVL = NUM_SLOT + 1,
  localparam int unsigned LVL_W   = $clog2(NUM_LVL + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_rd,
  input  logic               reg_wr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq_o
);
  logic [NUM_SLOT-1:0][DATA_W-1:0] slot_addr;
  logic [NUM_SLOT-1:0]             slot_en;
  logic [NUM_SLOT-1:0][SRC_W-1:0]  slot_sel;
  logic [NUM_SRC-1:0]              src_en;
  logic [DATA_W-1:0]               def_addr;
  logic [DATA_W-1:0]               cfg_rdata;
  logic [NUM_LVL-1:0]              isr_bits;
  logic [LVL_W-1:0]                isr_top;
  logic                            pend_valid;
  logic [LVL_W-1:0]                pend_lvl;
  logic                            ack;
  logic                            eoi;
  logic [DATA_W-1:0]               act_addr;
  logic                            cfg_wr;

  assign ack    = reg_rd && (reg_addr == OFF_ACTIVE);
  assign eoi    = reg_wr && (reg_addr == OFF_ACTIVE);
  assign cfg_wr = reg_wr && (reg_addr != OFF_ACTIVE);

  vic_regs #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .slot_addr (slot_addr),
    .slot_en   (slot_en),
    .slot_sel  (slot_sel),
    .src_en    (src_en),
    .def_addr  (def_addr),
    .cfg_rdata (cfg_rdata)
  );

  vic_prio #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT)) u_prio (
    .irq_src    (irq_src),
    .src_en     (src_en),
    .slot_en    (slot_en),
    .slot_sel   (slot_sel),
    .isr_top    (isr_top),
    .pend_valid (pend_valid),
    .pend_lvl   (pend_lvl)
  );

  vic_stack #(.NUM_LVL(NUM_LVL)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (ack && pend_valid),
    .push_lvl (pend_lvl),
    .pop      (eoi),
    .isr      (isr_bits),
    .top      (isr_top)
  );

  always_comb begin
    act_addr = def_addr;
    if (pend_valid && pend_lvl < LVL_W'(NUM_SLOT)) act_addr = slot_addr[pend_lvl[SLOT_W-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (ack)    reg_rdata <= act_addr;
    else if (reg_rd) reg_rdata <= cfg_rdata;
  end

  assign irq_o = pend_valid;
endmodule

// File: rtl/vic_ctrl_sva.sv
module vic_ctrl_sva #(
  parameter int unsigned NUM_LVL = 17
) (
  input logic               clk,
  input logic               rst_n,
  input logic               irq_o,
  input logic               ack,
  input logic               eoi,
  input logic [NUM_LVL-1:0] isr
);
  // R4: an acknowledge with a pending request adds exactly one in-service level
  a_r4_ack_pushes: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !eoi && irq_o) |=> ($countones(isr) == $past($countones(isr)) + 1));

  // R7: an acknowledge with nothing pending leaves the stack untouched
  a_r7_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !eoi && !irq_o) |=> (isr == $past(isr)));

  // R6: end of service retires exactly one level
  a_r6_eoi_pops: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack && isr != '0) |=> ($countones(isr) == $past($countones(isr)) - 1));

  // R6: end of service on an empty stack is ignored
  a_r6_empty_eoi: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack && isr == '0) |=> (isr == '0));

  // R5: nothing outranks level 0, so it blocks the IRQ line
  a_r5_top_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    isr[0] |-> !irq_o);

  // R4: the stack changes only on an acknowledge or end-of-service strobe
  a_r4_stack_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && !eoi) |=> $stable(isr));
endmodule

bind vic_ctrl vic_ctrl_sva #(.NUM_LVL(NUM_LVL)) u_sva (
  .clk   (clk),
  .rst_n (rst_n),
  .irq_o (irq_o),
  .ack   (ack),
  .eoi   (eoi),
  .isr   (isr_bits)
);

// File: tb/test_vic_ctrl.sv
`timescale 1ns/1ps
module test_vic_ctrl;
  localparam int NS = 32;
  localparam int NSL = 16;
  localparam logic [9:0] A_SEN = 10'h010, A_ACT = 10'h030, A_DEF = 10'h034;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_src = '0;
  logic [9:0]  reg_addr = '0;
  logic        reg_rd = 1'b0, reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;

  int vectors = 0, errors = 0;
  bit done = 1'b0;

  // reference model state
  logic [31:0] m_addr [NSL];
  bit          m_en   [NSL];
  int          m_sel  [NSL];
  logic [31:0] m_srcen, m_def;
  bit          m_isr  [NSL+1];

  vic_ctrl i_vic_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .reg_addr(reg_addr),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  always #5 clk = ~clk;

  function automatic int m_top();
    for (int i = 0; i <= NSL; i++) if (m_isr[i]) return i;
    return NSL + 1;
  endfunction

  function automatic int m_best();
    bit taken [NS];
    bit dflt = 0;
    for (int s = 0; s < NS; s++) taken[s] = 0;
    for (int k = 0; k < NSL; k++) if (m_en[k]) taken[m_sel[k]] = 1;
    for (int k = 0; k < NSL; k++)
      if (m_en[k] && irq_src[m_sel[k]] && m_srcen[m_sel[k]]) return k;
    for (int s = 0; s < NS; s++)
      if (irq_src[s] && m_srcen[s] && !taken[s]) dflt = 1;
    return dflt ? NSL : NSL + 1;
  endfunction

  function automatic bit m_irq();
    return m_best() < m_top();
  endfunction

  function automatic logic [31:0] m_cfg(logic [9:0] a);
    int k = int'(a[5:2]);
    if (a[9:8] == 2'b01 && a[7:6] == 2'b00 && a[1:0] == 2'b00) return m_addr[k];
    if (a[9:8] == 2'b10 && a[7:6] == 2'b00 && a[1:0] == 2'b00)
      return {26'd0, m_en[k], m_sel[k][4:0]};
    if (a == A_SEN) return m_srcen;
    if (a == A_DEF) return m_def;
    return 32'd0;
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // inputs are set at a falling edge before this is called
  task automatic tick(string tag);
    logic [31:0] exp_rd = 'x;
    bit do_rd = reg_rd;
    #1;
    check(tag, "irq_o", {31'd0, irq_o}, {31'd0, m_irq()});
    if (reg_rd) begin
      if (reg_addr == A_ACT) begin
        int b = m_best();
        if (b < m_top()) begin
          exp_rd = (b == NSL) ? m_def : m_addr[b];
          m_isr[b] = 1;
        end else exp_rd = m_def;
      end else exp_rd = m_cfg(reg_addr);
    end
    if (reg_wr) begin
      if (reg_addr == A_ACT) begin
        int t = m_top();
        if (t <= NSL) m_isr[t] = 0;
      end else if (reg_addr == A_SEN) m_srcen = reg_wdata;
      else if (reg_addr == A_DEF) m_def = reg_wdata;
      else if (reg_addr[9:8] == 2'b01 && reg_addr[7:6] == 0 && reg_addr[1:0] == 0)
        m_addr[reg_addr[5:2]] = reg_wdata;
      else if (reg_addr[9:8] == 2'b10 && reg_addr[7:6] == 0 && reg_addr[1:0] == 0) begin
        m_en[reg_addr[5:2]]  = reg_wdata[5];
        m_sel[reg_addr[5:2]] = int'(reg_wdata[4:0]);
      end
    end
    @(posedge clk);
    #1;
    if (do_rd) check(tag, "reg_rdata", reg_rdata, exp_rd);
    @(negedge clk);
    reg_rd = 0;
    reg_wr = 0;
  endtask

  task automatic rd(logic [9:0] a, string tag);
    reg_addr = a; reg_rd = 1; tick(tag);
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d, string tag);
    reg_addr = a; reg_wdata = d; reg_wr = 1; tick(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  task automatic slot(int k, int src, bit en, logic [31:0] a);
    wr(10'h100 + 10'(4 * k), a, "R9");
    wr(10'h200 + 10'(4 * k), {26'd0, en, 5'(src)}, "R9");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NSL; k++) begin m_addr[k] = 0; m_en[k] = 0; m_sel[k] = 0; end
    for (int k = 0; k <= NSL; k++) m_isr[k] = 0;
    m_srcen = 0; m_def = 0;
    repeat (3) @(negedge clk);
    check("R1", "irq_o in reset", {31'd0, irq_o}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    // R1: reset values
    rd(10'h104, "R1");
    rd(A_SEN, "R1");
    rd(A_ACT, "R1");
    // R9: programming and readback
    slot(0, 1, 1, 32'h0000_1000);
    slot(2, 7, 1, 32'h0000_1020);
    slot(5, 3, 1, 32'h0000_1050);
    slot(9, 20, 1, 32'h0000_1090);
    slot(11, 12, 0, 32'h0000_10B0);
    wr(A_SEN, 32'hBFFF_FFFF, "R9");
    wr(A_DEF, 32'hDEF0_0000, "R9");
    rd(10'h114, "R9");
    rd(10'h214, "R9");
    rd(10'h22C, "R9");
    rd(A_SEN, "R9");
    rd(A_DEF, "R9");
    // R2 / R4: slot 5 request, acknowledge, masking of lower slot 9
    irq_src[3] = 1; idle(2, "R5");
    rd(A_ACT, "R2");
    idle(1, "R4");
    irq_src[20] = 1; idle(2, "R4");
    // R10: slot 2 preempts slot 5
    irq_src[7] = 1; idle(1, "R10");
    rd(A_ACT, "R10");
    irq_src[7] = 0; idle(1, "R10");
    wr(A_ACT, 32'hFFFF_FFFF, "R6");
    idle(2, "R10");
    irq_src[3] = 0; idle(1, "R5");
    wr(A_ACT, 32'h0, "R6");
    // slot 9 now pending
    rd(A_ACT, "R2");
    irq_src[20] = 0;
    wr(A_ACT, 32'h1234_5678, "R6");
    // R3: default level, masked line 30 has no effect, disabled slot 11 line 12 falls to default
    irq_src[30] = 1; idle(2, "R3");
    irq_src[12] = 1; idle(1, "R3");
    irq_src[1] = 1;  idle(1, "R2");
    rd(A_ACT, "R2");
    idle(1, "R4");
    irq_src[1] = 0; idle(1, "R3");
    wr(A_ACT, 32'h0, "R6");
    rd(A_ACT, "R3");
    // R8: request drops right after the acknowledge strobe; data still the default
    irq_src[12] = 0; idle(1, "R8");
    wr(A_ACT, 32'h0, "R6");
    irq_src[30] = 0;
    // R7 / R6: nothing pending, empty-stack end of service
    rd(A_ACT, "R7");
    wr(A_ACT, 32'hA5A5_A5A5, "R6");
    irq_src[3] = 1; idle(1, "R6");
    rd(A_ACT, "R8");
    irq_src[3] = 0; idle(1, "R8");
    wr(A_ACT, 32'h0, "R6");
    // mixed traffic against the model
    for (int n = 0; n < 400; n++) begin
      int pick = $urandom_range(0, 6);
      int lines [7] = '{1, 3, 7, 12, 20, 30, 25};
      int act = $urandom_range(0, 9);
      if ($urandom_range(0, 2) == 0) irq_src[lines[pick]] = ~irq_src[lines[pick]];
      if (act < 3 && (irq_o || act == 0)) rd(A_ACT, "R5");
      else if (act == 4) wr(A_ACT, $urandom, "R6");
      else tick("R5");
    end
    irq_src = '0;
    for (int k = 0; k < 20; k++) wr(A_ACT, 32'h0, "R6");
    rd(A_ACT, "R7");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule